// File: doc/BRIEF.md
# Timing-Error Aggregation and Instruction Invalidation

This block gathers the timing-error flags raised by the error-detecting capture flops of each pipeline stage and turns them into a per-instruction error mark. Each capture flop reports a late data transition seen during the high clock phase. All flags of a stage are merged by an OR tree, and the result is attached to the instruction that occupies that stage. The mark travels down the pipeline with the instruction. Later stages add their own flags to it. It is acted on only when the instruction reaches the write-back stage.

At write-back, a clean instruction receives a commit enable. A marked instruction is denied its commit. Instead the block emits a one-cycle recovery request that carries the instruction's tag. In the same step it squashes every younger instruction still in flight, so that replay restarts from the errant one. The pipeline moves only when the stage-advance enable is high. While it is stalled, each held instruction keeps collecting any flags raised in its stage.

Top module: `terr_agg`

## Requirements
- R1: After reset, all stage valid bits, the commit enable, the recovery request and the recovery tag are 0.
- R2: When the advance input is high at a clock edge, every instruction moves one stage and stage 0 loads the incoming valid bit and tag. When it is low, the stage valid bits keep their value.
- R3: If any single bit of a stage's flag vector is set while that stage holds a valid instruction, that instruction is marked as errant. This holds for any bit position. Stage s owns flag bits s*FLAGS_W to s*FLAGS_W+FLAGS_W-1.
- R4: A mark picked up in any stage stays with the instruction until write-back. Flags from later stages are ORed into the mark and never clear it.
- R5: When an unmarked valid instruction leaves the last stage on an advance edge, commit_o is 1 for exactly the following cycle.
- R6: When a marked valid instruction leaves the last stage on an advance edge, commit_o stays 0. In the following cycle recover_o is 1 for one cycle, and recover_tag_o holds that instruction's tag until the next recovery.
- R7: Flags raised in a stage that holds no valid instruction have no effect: no mark, no commit change and no recovery.
- R8: On the edge that starts a recovery, all younger instructions are squashed, including one offered at stage 0. All stage valid bits read 0 in the cycle that recover_o is high.
- R9: While the advance input is low, flags raised in a stage are latched into the held instruction's mark. They still cause a recovery after the flag input has returned to 0.
- R10: commit_o and recover_o are never high together, and neither is high in a cycle that follows an edge at which the advance input was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Stage-advance enable |
| in_valid_i | input | 1 | Valid bit of the instruction entering stage 0 |
| in_tag_i | input | TAG_W | Tag of the instruction entering stage 0 |
| err_flags_i | input | NSTG*FLAGS_W | Per-stage timing-error flags, FLAGS_W bits per stage, stage 0 in the low bits |
| stage_valid_o | output | NSTG | Valid bit of each stage, bit NSTG-1 being write-back |
| commit_o | output | 1 | Commit enable pulse for a clean retiring instruction |
| recover_o | output | 1 | One-cycle recovery request for an errant retiring instruction |
| recover_tag_o | output | TAG_W | Tag of the most recent errant instruction |

## Verification
Two events can meet on one advance edge. A flagged instruction is retiring at write-back while a fresh valid instruction is offered at stage 0 and other valid instructions fill the middle stages. The bench fills the whole pipeline back to back and then flags the write-back slot on the same edge that admits a new instruction. The squash must win over both the load and the shift: every valid bit reads 0 next to the recovery pulse, and no commit appears. The random phase keeps the pipeline densely populated with sparse flags, so these overlaps recur, and a bench-side model judges every cycle.

// File: rtl/terr_agg_pkg.sv
package terr_agg_pkg;
   typedef enum logic [1:0] {
      RET_NONE   = 2'd0,
      RET_COMMIT = 2'd1,
      RET_KILL   = 2'd2
   } retire_e;
endpackage

// File: rtl/terr_or_tree.sv
module terr_or_tree #(
   parameter int W = 8
) (
   input  logic [W-1:0] bits_i,
   output logic         any_o
);
   localparam int LVL = (W > 1) ? $clog2(W) : 0;
   localparam int P   = 1 << LVL;

   logic [2*P-2:0] node;

   for (genvar k = 0; k < P; k++) begin : g_leaf
      if (k < W) begin : g_real
         assign node[P-1+k] = bits_i[k];
      end else begin : g_pad
         assign node[P-1+k] = 1'b0;
      end
   end

   for (genvar i = 0; i < P-1; i++) begin : g_node
      assign node[i] = node[2*i+1] | node[2*i+2];
   end

   assign any_o = node[0];
endmodule

// File: rtl/terr_slot.sv
module terr_slot #(
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic             kill_i,
   input  logic             up_valid_i,
   input  logic [TAG_W-1:0] up_tag_i,
   input  logic             up_err_i,
   input  logic             flag_i,
   output logic             valid_o,
   output logic [TAG_W-1:0] tag_o,
   output logic             err_o
);
   logic err_q;

   // mark as seen by the next stage: carried mark plus this stage's flags
   assign err_o = err_q | (valid_o & flag_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         tag_o   <= '0;
         err_q   <= 1'b0;
      end else if (kill_i) begin
         valid_o <= 1'b0;
         err_q   <= 1'b0;
      end else if (adv_i) begin
         valid_o <= up_valid_i;
         tag_o   <= up_tag_i;
         err_q   <= up_valid_i & up_err_i;
      end else begin
         err_q   <= err_o;
      end
   end
endmodule

// File: rtl/terr_agg.sv
module terr_agg
   import terr_agg_pkg::*;
#(
   parameter int NSTG    = 4,
   parameter int FLAGS_W = 8,
   parameter int TAG_W   = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adv_i,
   input  logic                    in_valid_i,
   input  logic [TAG_W-1:0]        in_tag_i,
   input  logic [NSTG*FLAGS_W-1:0] err_flags_i,
   output logic [NSTG-1:0]         stage_valid_o,
   output logic                    commit_o,
   output logic                    recover_o,
   output logic [TAG_W-1:0]        recover_tag_o
);
   localparam int LAST = NSTG - 1;

   if (NSTG < 2) begin : g_bad_nstg
      $error("terr_agg: NSTG must be at least 2");
   end
   if (FLAGS_W < 1) begin : g_bad_flags
      $error("terr_agg: FLAGS_W must be at least 1");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("terr_agg: TAG_W must be at least 1");
   end

   logic [NSTG-1:0] v_q;
   logic [NSTG-1:0] eff;
   logic [NSTG-1:0] stg_flag;
   logic [TAG_W-1:0] tag_q [NSTG];
   logic kill;
   retire_e ret;

   for (genvar s = 0; s < NSTG; s++) begin : g_stage
      logic             up_v;
      logic [TAG_W-1:0] up_t;
      logic             up_e;

      terr_or_tree #(.W(FLAGS_W)) u_or (
         .bits_i (err_flags_i[s*FLAGS_W +: FLAGS_W]),
         .any_o  (stg_flag[s])
      );

      if (s == 0) begin : g_head
         assign up_v = in_valid_i;
         assign up_t = in_tag_i;
         assign up_e = 1'b0;
      end else begin : g_body
         assign up_v = v_q[s-1];
         assign up_t = tag_q[s-1];
         assign up_e = eff[s-1];
      end

      terr_slot #(.TAG_W(TAG_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .adv_i      (adv_i),
         .kill_i     (kill),
         .up_valid_i (up_v),
         .up_tag_i   (up_t),
         .up_err_i   (up_e),
         .flag_i     (stg_flag[s]),
         .valid_o    (v_q[s]),
         .tag_o      (tag_q[s]),
         .err_o      (eff[s])
      );
   end

   always_comb begin
      if (!(adv_i && v_q[LAST]))
         ret = RET_NONE;
      else if (eff[LAST])
         ret = RET_KILL;
      else
         ret = RET_COMMIT;
   end

   assign kill = (ret == RET_KILL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit_o      <= 1'b0;
         recover_o     <= 1'b0;
         recover_tag_o <= '0;
      end else begin
         commit_o  <= (ret == RET_COMMIT);
         recover_o <= (ret == RET_KILL);
         if (ret == RET_KILL)
            recover_tag_o <= tag_q[LAST];
      end
   end

   assign stage_valid_o = v_q;
endmodule

// File: rtl/terr_agg_chk.sv
module terr_agg_chk #(
   parameter int NSTG = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            adv_i,
   input logic [NSTG-1:0] stage_valid_o,
   input logic            commit_o,
   input logic            recover_o
);
   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_o && recover_o));

   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> (!commit_o && !recover_o));

   p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      recover_o |=> !recover_o);

   p_squash_r8: assert property (@(posedge clk) disable iff (!rst_n)
      recover_o |-> (stage_valid_o == '0));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(stage_valid_o));
endmodule

bind terr_agg terr_agg_chk #(.NSTG(NSTG)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .adv_i         (adv_i),
   .stage_valid_o (stage_valid_o),
   .commit_o      (commit_o),
   .recover_o     (recover_o)
);

// File: tb/terr_agg_tb.sv
module terr_agg_tb_top;
   localparam int NSTG    = 4;
   localparam int FLAGS_W = 8;
   localparam int TAG_W   = 6;
   localparam int NW      = NSTG * FLAGS_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic adv = 1'b0;
   logic iv = 1'b0;
   logic [TAG_W-1:0] itag = '0;
   logic [NW-1:0] flags = '0;
   logic [NSTG-1:0] sv;
   logic commit, rec;
   logic [TAG_W-1:0] rtag;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // bench model of the requirements
   bit mv [NSTG];
   bit me [NSTG];
   logic [TAG_W-1:0] mt [NSTG];
   bit x_commit, x_rec;
   logic [TAG_W-1:0] x_rtag;

   always #4 clk = ~clk;   // 125 MHz

   terr_agg #(.NSTG(NSTG), .FLAGS_W(FLAGS_W), .TAG_W(TAG_W)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .adv_i         (adv),
      .in_valid_i    (iv),
      .in_tag_i      (itag),
      .err_flags_i   (flags),
      .stage_valid_o (sv),
      .commit_o      (commit),
      .recover_o     (rec),
      .recover_tag_o (rtag)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [NW-1:0] one_flag(input int s, input int b);
      logic [NW-1:0] f = '0;
      f[s*FLAGS_W + b] = 1'b1;
      return f;
   endfunction

   task automatic compare(input string lbl);
      logic [NSTG-1:0] xv;
      for (int s = 0; s < NSTG; s++) xv[s] = mv[s];
      chk(sv == xv, lbl, "stage_valid", 32'(sv), 32'(xv));
      chk(commit == x_commit, lbl, "commit", 32'(commit), 32'(x_commit));
      chk(rec == x_rec, lbl, "recover", 32'(rec), 32'(x_rec));
      chk(rtag == x_rtag, lbl, "recover_tag", 32'(rtag), 32'(x_rtag));
      chk(!(commit && rec), "R10", "commit_and_recover", 32'({commit, rec}), 32'd0);
   endtask

   // called just after a falling edge; drives, models, then checks at the next falling edge
   task automatic step(input bit a, input bit v, input logic [TAG_W-1:0] t,
                       input logic [NW-1:0] f, input string lbl);
      bit eff [NSTG];
      bit kill;
      adv = a; iv = v; itag = t; flags = f;
      for (int s = 0; s < NSTG; s++)
         eff[s] = me[s] | (mv[s] & (|f[s*FLAGS_W +: FLAGS_W]));
      kill = a && mv[NSTG-1] && eff[NSTG-1];
      x_commit = a && mv[NSTG-1] && !eff[NSTG-1];
      x_rec = kill;
      if (kill) x_rtag = mt[NSTG-1];
      if (kill) begin
         for (int s = 0; s < NSTG; s++) begin mv[s] = 0; me[s] = 0; end
      end else if (a) begin
         for (int s = NSTG-1; s > 0; s--) begin
            mv[s] = mv[s-1]; mt[s] = mt[s-1]; me[s] = mv[s-1] & eff[s-1];
         end
         mv[0] = v; mt[0] = t; me[0] = 0;
      end else begin
         for (int s = 0; s < NSTG; s++) me[s] = eff[s];
      end
      @(posedge clk);
      @(negedge clk);
      compare(lbl);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int s = 0; s < NSTG; s++) begin mv[s] = 0; me[s] = 0; mt[s] = '0; end
      x_commit = 0; x_rec = 0; x_rtag = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      compare("R1");

      // R3: highest flag bit of stage 2 marks instruction 5
      step(1, 1, 6'd5, '0, "R3");
      step(1, 0, '0, '0, "R3");
      step(1, 0, '0, '0, "R3");
      step(1, 0, '0, one_flag(2, FLAGS_W-1), "R3");
      step(1, 0, '0, '0, "R3");
      chk(rtag == 6'd5, "R3", "errant_tag", 32'(rtag), 32'd5);

      // R4 and R5: early mark carried; clean neighbour commits
      step(1, 1, 6'd11, one_flag(0, 0), "R4");
      step(1, 1, 6'd12, one_flag(0, 3), "R4");
      step(1, 0, '0, one_flag(1, 3) | one_flag(2, 1), "R4");
      step(1, 0, '0, '0, "R4");
      step(1, 0, '0, '0, "R4");
      step(1, 1, 6'd13, '0, "R5");
      for (int i = 0; i < NSTG; i++) step(1, 0, '0, '0, "R5");

      // R7: flags on bubbles
      for (int i = 0; i < NSTG + 2; i++) step(1, 0, '0, '1, "R7");
      step(0, 0, '0, '1, "R7");

      // R8: full pipeline, kill at write-back while a new one enters
      for (int i = 1; i <= NSTG; i++) step(1, 1, 6'(i + 20), '0, "R8");
      step(1, 1, 6'd40, one_flag(NSTG-1, 2), "R8");
      chk(sv == '0, "R8", "squash", 32'(sv), 32'd0);
      step(1, 0, '0, '0, "R8");

      // R9: flag during a stall, cleared before moving on
      step(1, 1, 6'd33, '0, "R9");
      step(1, 0, '0, '0, "R9");
      step(0, 0, '0, one_flag(1, 4), "R9");
      step(0, 0, '0, '0, "R9");
      for (int i = 0; i < NSTG; i++) step(1, 0, '0, '0, "R9");
      chk(rtag == 6'd33, "R9", "stall_tag", 32'(rtag), 32'd33);

      // R2, R6: random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [NW-1:0] f = '0;
         for (int s = 0; s < NSTG; s++)
            if ($urandom % 24 == 0) f |= one_flag(s, int'($urandom % FLAGS_W));
         step(($urandom % 4) != 0, ($urandom % 5) != 0, 6'($urandom), f,
              ($urandom % 2) ? "R2" : "R6");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule